// File: doc/BRIEF.md
# DMA Controller Global Register Bank

This block is the shared control and status register file of a multi-channel DMA engine, with up to 64 channels. Software reaches it through a plain 32-bit write port and a combinational read port. It holds a three-bit arbitration and clock control word, an auxiliary word with a cache-snoop enable, and a first-error status word. It also keeps five per-channel bit arrays: request enable, error-interrupt enable, interrupt pending, error pending and done. Each array is split into a low word for channels 0–31 and a high word for channels 32–63. Eight command ports take a channel number in the low byte of the write data, and each one sets or clears a single channel's bit.

The channel engines report a completion pulse, an error pulse and a ten-bit error cause for each channel. The bank returns a request-enable level and a one-cycle start pulse to each channel, plus a single interrupt line. The first-error capture is a two-state machine. In ERR_ARMED it waits for any channel error. The capture transition then moves it to ERR_HELD and records the lowest-numbered failing channel together with its cause. In ERR_HELD the word stays frozen. The rearm transition back to ERR_ARMED happens when software clears the error-pending bit of the recorded channel, and rearming zeroes the word.

Top module: `dmac_regbank`

## Requirements
- R1: After reset, every readable word reads zero, irq is low, no ch_start bit is set and all cfg outputs are low.
- R2: Channel c uses bit c of the low word (offsets 0x08, 0x10, 0x18, 0x20, 0x28) when c < 32, and bit c-32 of the high word (offsets 0x0C, 0x14, 0x1C, 0x24, 0x2C) otherwise.
- R3: The request-enable words (0x08/0x0C) are read-write and drive ch_req_en. Port 0x40 sets one channel's bit and port 0x44 clears it.
- R4: The error-interrupt-enable words (0x10/0x14) are read-write. Port 0x48 sets one channel's bit and port 0x4C clears it.
- R5: A ch_done pulse sets that channel's done bit (0x28/0x2C, read-only) and its interrupt-pending bit. Port 0x5C clears the done bit.
- R6: Writing ones to the interrupt-pending words (0x18/0x1C) clears those bits, and so does port 0x50. A hardware set in the same cycle wins over the clear.
- R7: A ch_err pulse sets the error-pending bit (0x20/0x24). Writing ones to that word clears bits, and so does port 0x54. A hardware set wins over a clear in the same cycle.
- R8: irq is high while any interrupt-pending bit is set, or while any error-pending bit is set whose error-interrupt enable is also set.
- R9: A write of channel c to port 0x58 raises ch_start[c] for exactly the one cycle after the write.
- R10: When armed, the error word at 0x04 captures the lowest-numbered erroring channel. Its layout is bit 31 valid, bits 13:8 channel, bits 15:14 from cause[9:8] and bits 7:0 from cause[7:0].
- R11: While valid, the error word holds against new errors. Clearing the recorded channel's pending error zeroes the word and rearms capture. Clearing any other channel's pending error does neither.
- R12: A command-port value of NUM_CH or greater changes no bit and gives no start pulse.
- R13: Control word 0x00 keeps only bits 31 (clock gating), 3 (group round-robin) and 2 (channel round-robin), which drive the cfg outputs. Word 0x30 keeps only bit 6 (snoop enable). All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte address of the word accessed |
| bus_wdata | input | 32 | Write data; command ports use bits 7:0 |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| ch_done | input | NUM_CH | Per-channel completion pulse |
| ch_err | input | NUM_CH | Per-channel error pulse |
| ch_cause | input | NUM_CH*10 | Per-channel error cause, 10 bits per channel |
| ch_req_en | output | NUM_CH | Per-channel request enable |
| ch_start | output | NUM_CH | Per-channel one-cycle start pulse |
| irq | output | 1 | Combined interrupt line |
| cfg_clk_gate | output | 1 | Dynamic clock gating enable |
| cfg_rr_group | output | 1 | Round-robin group arbitration |
| cfg_rr_chan | output | 1 | Round-robin channel arbitration |
| cfg_snoop | output | 1 | Cache snoop enable |

## Verification
A register write or a channel pulse takes effect at the clock edge that samples it. Read data and irq therefore show the new state in the cycle right after that edge, and ch_start is high only during that cycle. The bench drives every input at the falling edge. A behavioural model advances at the rising edge from the same inputs. At each falling edge the bench compares ch_req_en, ch_start, irq and the cfg outputs against the model. Register reads are set up at a falling edge and sampled a short delay later, before the next rising edge.

// File: rtl/dmac_regs_pkg.sv
package dmac_regs_pkg;
    localparam int CAUSE_W = 10;
    localparam int NUM_CMD = 8;

    localparam logic [7:0] A_CTRL    = 8'h00;
    localparam logic [7:0] A_ERRSTAT = 8'h04;
    localparam logic [7:0] A_REQEN_L = 8'h08;
    localparam logic [7:0] A_REQEN_H = 8'h0C;
    localparam logic [7:0] A_EIEN_L  = 8'h10;
    localparam logic [7:0] A_EIEN_H  = 8'h14;
    localparam logic [7:0] A_INTP_L  = 8'h18;
    localparam logic [7:0] A_INTP_H  = 8'h1C;
    localparam logic [7:0] A_ERRP_L  = 8'h20;
    localparam logic [7:0] A_ERRP_H  = 8'h24;
    localparam logic [7:0] A_DONE_L  = 8'h28;
    localparam logic [7:0] A_DONE_H  = 8'h2C;
    localparam logic [7:0] A_AUX     = 8'h30;
    localparam logic [7:0] A_CMD0    = 8'h40;

    // command port k lives at A_CMD0 + 4*k
    localparam int CMD_SET_REQ = 0;
    localparam int CMD_CLR_REQ = 1;
    localparam int CMD_SET_EIE = 2;
    localparam int CMD_CLR_EIE = 3;
    localparam int CMD_CLR_INT = 4;
    localparam int CMD_CLR_ERR = 5;
    localparam int CMD_START   = 6;
    localparam int CMD_CLR_DNE = 7;

    typedef enum logic {ERR_ARMED, ERR_HELD} err_state_e;
endpackage

// File: rtl/dmac_cmd_decode.sv
module dmac_cmd_decode #(
    parameter int NUM_CH = 64
) (
    input  logic              stb,
    input  logic [7:0]        code,
    output logic [NUM_CH-1:0] hit
);
    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            hit[i] = stb && (code == 8'(i));
        end
    end
endmodule

// File: rtl/dmac_bitvec.sv
module dmac_bitvec #(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_v,
    input  logic [N-1:0] clr_v,
    output logic [N-1:0] q
);
    // set has priority over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= (q & ~clr_v) | set_v;
    end
endmodule

// File: rtl/dmac_err_capture.sv
module dmac_err_capture
    import dmac_regs_pkg::*;
#(
    parameter int NUM_CH = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH-1:0]         ch_err,
    input  logic [NUM_CH*CAUSE_W-1:0] ch_cause,
    input  logic [NUM_CH-1:0]         sw_clr,
    output logic [31:0]               err_word
);
    err_state_e         state_q, state_d;
    logic               hit_any;
    logic [5:0]         hit_idx;
    logic [CAUSE_W-1:0] hit_cause;
    logic               rearm;
    logic [5:0]         chan_q;
    logic [CAUSE_W-1:0] cause_q;

    // lowest-numbered failing channel wins
    always_comb begin
        hit_any   = 1'b0;
        hit_idx   = '0;
        hit_cause = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (ch_err[i]) begin
                hit_any   = 1'b1;
                hit_idx   = 6'(i);
                hit_cause = ch_cause[i*CAUSE_W +: CAUSE_W];
            end
        end
    end

    always_comb begin
        rearm = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (chan_q == 6'(i) && sw_clr[i]) rearm = 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ERR_ARMED: if (hit_any) state_d = ERR_HELD;
            ERR_HELD:  if (rearm)   state_d = ERR_ARMED;
            default:   state_d = ERR_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ERR_ARMED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q  <= '0;
            cause_q <= '0;
        end else begin
            unique case (state_q)
                ERR_ARMED: if (hit_any) begin
                    chan_q  <= hit_idx;
                    cause_q <= hit_cause;
                end
                ERR_HELD: if (rearm) begin
                    chan_q  <= '0;
                    cause_q <= '0;
                end
                default: ;
            endcase
        end
    end

    assign err_word = {state_q == ERR_HELD, 15'b0, cause_q[9:8], chan_q, cause_q[7:0]};
endmodule

// File: rtl/dmac_regbank.sv
module dmac_regbank
    import dmac_regs_pkg::*;
#(
    parameter int NUM_CH = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_we,
    input  logic [7:0]                bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [NUM_CH-1:0]         ch_done,
    input  logic [NUM_CH-1:0]         ch_err,
    input  logic [NUM_CH*CAUSE_W-1:0] ch_cause,
    output logic [NUM_CH-1:0]         ch_req_en,
    output logic [NUM_CH-1:0]         ch_start,
    output logic                      irq,
    output logic                      cfg_clk_gate,
    output logic                      cfg_rr_group,
    output logic                      cfg_rr_chan,
    output logic                      cfg_snoop
);
    logic [NUM_CH-1:0] cmd_hit [NUM_CMD];
    logic [NUM_CH-1:0] rq_set, rq_clr, ei_set, ei_clr;
    logic [NUM_CH-1:0] ip_clr, ep_clr, dn_clr;
    logic [NUM_CH-1:0] reqen_q, eien_q, intp_q, errp_q, done_q;
    logic [2:0]        ctrl_q;
    logic              snoop_q;
    logic [NUM_CH-1:0] start_q;
    logic [31:0]       err_status;

    for (genvar k = 0; k < NUM_CMD; k++) begin : g_cmd
        dmac_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
            .stb  (bus_we && bus_addr == A_CMD0 + 8'(4*k)),
            .code (bus_wdata[7:0]),
            .hit  (cmd_hit[k])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int         BIT = c % 32;
        localparam logic [7:0] ARQ = (c < 32) ? A_REQEN_L : A_REQEN_H;
        localparam logic [7:0] AEI = (c < 32) ? A_EIEN_L  : A_EIEN_H;
        localparam logic [7:0] AIP = (c < 32) ? A_INTP_L  : A_INTP_H;
        localparam logic [7:0] AEP = (c < 32) ? A_ERRP_L  : A_ERRP_H;
        logic wb;
        assign wb = bus_wdata[BIT];
        assign rq_set[c] = (bus_we && bus_addr == ARQ &&  wb) || cmd_hit[CMD_SET_REQ][c];
        assign rq_clr[c] = (bus_we && bus_addr == ARQ && !wb) || cmd_hit[CMD_CLR_REQ][c];
        assign ei_set[c] = (bus_we && bus_addr == AEI &&  wb) || cmd_hit[CMD_SET_EIE][c];
        assign ei_clr[c] = (bus_we && bus_addr == AEI && !wb) || cmd_hit[CMD_CLR_EIE][c];
        assign ip_clr[c] = (bus_we && bus_addr == AIP &&  wb) || cmd_hit[CMD_CLR_INT][c];
        assign ep_clr[c] = (bus_we && bus_addr == AEP &&  wb) || cmd_hit[CMD_CLR_ERR][c];
        assign dn_clr[c] = cmd_hit[CMD_CLR_DNE][c];
    end

    dmac_bitvec #(.N(NUM_CH)) u_reqen (.clk(clk), .rst_n(rst_n), .set_v(rq_set),  .clr_v(rq_clr), .q(reqen_q));
    dmac_bitvec #(.N(NUM_CH)) u_eien  (.clk(clk), .rst_n(rst_n), .set_v(ei_set),  .clr_v(ei_clr), .q(eien_q));
    dmac_bitvec #(.N(NUM_CH)) u_intp  (.clk(clk), .rst_n(rst_n), .set_v(ch_done), .clr_v(ip_clr), .q(intp_q));
    dmac_bitvec #(.N(NUM_CH)) u_errp  (.clk(clk), .rst_n(rst_n), .set_v(ch_err),  .clr_v(ep_clr), .q(errp_q));
    dmac_bitvec #(.N(NUM_CH)) u_done  (.clk(clk), .rst_n(rst_n), .set_v(ch_done), .clr_v(dn_clr), .q(done_q));

    dmac_err_capture #(.NUM_CH(NUM_CH)) u_errcap (
        .clk      (clk),
        .rst_n    (rst_n),
        .ch_err   (ch_err),
        .ch_cause (ch_cause),
        .sw_clr   (ep_clr),
        .err_word (err_status)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            snoop_q <= 1'b0;
            start_q <= '0;
        end else begin
            start_q <= cmd_hit[CMD_START];
            if (bus_we && bus_addr == A_CTRL) ctrl_q  <= {bus_wdata[31], bus_wdata[3], bus_wdata[2]};
            if (bus_we && bus_addr == A_AUX)  snoop_q <= bus_wdata[6];
        end
    end

    function automatic logic [31:0] pack_word(input logic [NUM_CH-1:0] v, input int base);
        logic [31:0] w;
        w = '0;
        for (int i = 0; i < 32; i++) begin
            if (base + i < NUM_CH) w[i] = v[base + i];
        end
        return w;
    endfunction

    always_comb begin
        case (bus_addr)
            A_CTRL:    bus_rdata = {ctrl_q[2], 27'b0, ctrl_q[1], ctrl_q[0], 2'b0};
            A_ERRSTAT: bus_rdata = err_status;
            A_REQEN_L: bus_rdata = pack_word(reqen_q, 0);
            A_REQEN_H: bus_rdata = pack_word(reqen_q, 32);
            A_EIEN_L:  bus_rdata = pack_word(eien_q, 0);
            A_EIEN_H:  bus_rdata = pack_word(eien_q, 32);
            A_INTP_L:  bus_rdata = pack_word(intp_q, 0);
            A_INTP_H:  bus_rdata = pack_word(intp_q, 32);
            A_ERRP_L:  bus_rdata = pack_word(errp_q, 0);
            A_ERRP_H:  bus_rdata = pack_word(errp_q, 32);
            A_DONE_L:  bus_rdata = pack_word(done_q, 0);
            A_DONE_H:  bus_rdata = pack_word(done_q, 32);
            A_AUX:     bus_rdata = {25'b0, snoop_q, 6'b0};
            default:   bus_rdata = '0;
        endcase
    end

    assign ch_req_en    = reqen_q;
    assign ch_start     = start_q;
    assign irq          = (|intp_q) || (|(errp_q & eien_q));
    assign cfg_clk_gate = ctrl_q[2];
    assign cfg_rr_group = ctrl_q[1];
    assign cfg_rr_chan  = ctrl_q[0];
    assign cfg_snoop    = snoop_q;
endmodule

// File: rtl/dmac_regbank_chk.sv
module dmac_regbank_chk
    import dmac_regs_pkg::*;
#(
    parameter int NUM_CH = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [7:0]        bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [NUM_CH-1:0] ch_done,
    input logic [NUM_CH-1:0] ch_err,
    input logic [NUM_CH-1:0] ch_start,
    input logic              irq,
    input logic [31:0]       err_status
);
    localparam logic [7:0] A_START = A_CMD0 + 8'(4*CMD_START);
    localparam logic [7:0] A_CLRE  = A_CMD0 + 8'(4*CMD_CLR_ERR);

    logic start_ok, start_bad, err_clear_wr;
    assign start_ok     = bus_we && bus_addr == A_START && (32'(bus_wdata[7:0]) <  NUM_CH);
    assign start_bad    = bus_we && bus_addr == A_START && (32'(bus_wdata[7:0]) >= NUM_CH);
    assign err_clear_wr = bus_we && (bus_addr == A_CLRE || bus_addr == A_ERRP_L || bus_addr == A_ERRP_H);

    p_start_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_start));
    p_start_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> $countones(ch_start) == 1);
    p_start_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        start_bad |=> ch_start == '0);
    p_done_raises_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_done) |=> irq);
    p_err_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_status[31] && (|ch_err)) |=> err_status[31]);
    p_err_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_status[31] && !err_clear_wr) |=> $stable(err_status));
endmodule

bind dmac_regbank dmac_regbank_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .ch_done    (ch_done),
    .ch_err     (ch_err),
    .ch_start   (ch_start),
    .irq        (irq),
    .err_status (err_status)
);

// File: tb/dmac_regbank_tb.sv
module dmac_regbank_tb;
    localparam int N  = 64;
    localparam int CW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  ch_done = '0, ch_err = '0;
    logic [N*CW-1:0] ch_cause = '0;
    logic [N-1:0]  ch_req_en, ch_start;
    logic          irq, cfg_clk_gate, cfg_rr_group, cfg_rr_chan, cfg_snoop;

    int n_chk = 0, n_fail = 0;

    dmac_regbank #(.NUM_CH(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_done(ch_done),
        .ch_err(ch_err), .ch_cause(ch_cause), .ch_req_en(ch_req_en),
        .ch_start(ch_start), .irq(irq), .cfg_clk_gate(cfg_clk_gate),
        .cfg_rr_group(cfg_rr_group), .cfg_rr_chan(cfg_rr_chan), .cfg_snoop(cfg_snoop)
    );

    always #5 clk = ~clk;

    // behavioural reference model
    logic [N-1:0] m_req, m_eie, m_int, m_err, m_dne, m_start;
    logic [N-1:0] k_int, k_err;
    logic [31:0]  m_ctrl;
    logic         m_snoop, m_valid;
    int           m_ch;
    logic [CW-1:0] m_cause;
    int           cmd;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_req = '0; m_eie = '0; m_int = '0; m_err = '0; m_dne = '0; m_start = '0;
            m_ctrl = '0; m_snoop = 1'b0; m_valid = 1'b0; m_ch = 0; m_cause = '0;
        end else begin
            k_int = '0; k_err = '0; m_start = '0;
            cmd = int'(bus_wdata[7:0]);
            if (bus_we) begin
                case (bus_addr)
                    8'h00: m_ctrl = bus_wdata & 32'h8000_000C;
                    8'h08: m_req[31:0]  = bus_wdata;
                    8'h0C: m_req[63:32] = bus_wdata;
                    8'h10: m_eie[31:0]  = bus_wdata;
                    8'h14: m_eie[63:32] = bus_wdata;
                    8'h18: k_int[31:0]  = bus_wdata;
                    8'h1C: k_int[63:32] = bus_wdata;
                    8'h20: k_err[31:0]  = bus_wdata;
                    8'h24: k_err[63:32] = bus_wdata;
                    8'h30: m_snoop = bus_wdata[6];
                    default: if (bus_addr >= 8'h40 && bus_addr <= 8'h5C && cmd < N) begin
                        case (bus_addr)
                            8'h40: m_req[cmd] = 1'b1;
                            8'h44: m_req[cmd] = 1'b0;
                            8'h48: m_eie[cmd] = 1'b1;
                            8'h4C: m_eie[cmd] = 1'b0;
                            8'h50: k_int[cmd] = 1'b1;
                            8'h54: k_err[cmd] = 1'b1;
                            8'h58: m_start[cmd] = 1'b1;
                            8'h5C: m_dne[cmd] = 1'b0;
                            default: ;
                        endcase
                    end
                endcase
            end
            if (!m_valid) begin
                for (int i = N - 1; i >= 0; i--) begin
                    if (ch_err[i]) begin
                        m_valid = 1'b1; m_ch = i; m_cause = ch_cause[i*CW +: CW];
                    end
                end
            end else if (k_err[m_ch]) begin
                m_valid = 1'b0; m_ch = 0; m_cause = '0;
            end
            m_int = (m_int & ~k_int) | ch_done;
            m_err = (m_err & ~k_err) | ch_err;
            m_dne = m_dne | ch_done;
        end
    end

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h00: return m_ctrl;
            8'h04: return {m_valid, 15'b0, m_cause[9:8], 6'(m_ch), m_cause[7:0]};
            8'h08: return m_req[31:0];
            8'h0C: return m_req[63:32];
            8'h10: return m_eie[31:0];
            8'h14: return m_eie[63:32];
            8'h18: return m_int[31:0];
            8'h1C: return m_int[63:32];
            8'h20: return m_err[31:0];
            8'h24: return m_err[63:32];
            8'h28: return m_dne[31:0];
            8'h2C: return m_dne[63:32];
            8'h30: return {25'b0, m_snoop, 6'b0};
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-clock comparison of registered outputs
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 ch_req_en", ch_req_en, m_req);
            chk("R9 ch_start", ch_start, m_start);
            chk("R8 irq", 64'(irq), 64'((|m_int) || (|(m_err & m_eie))));
            chk("R13 cfg", 64'({cfg_clk_gate, cfg_rr_group, cfg_rr_chan, cfg_snoop}),
                64'({m_ctrl[31], m_ctrl[3], m_ctrl[2], m_snoop}));
        end
    end

    // one cycle of stimulus, starting and ending at a falling edge
    task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d,
                        input logic [N-1:0] dn, input logic [N-1:0] er);
        bus_we = we; bus_addr = a; bus_wdata = d; ch_done = dn; ch_err = er;
        @(negedge clk);
        bus_we = 1'b0; ch_done = '0; ch_err = '0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(1'b1, a, d, '0, '0);
    endtask

    task automatic rd(input string tag, input logic [7:0] a);
        bus_addr = a;
        #1;
        chk(tag, 64'(bus_rdata), 64'(m_read(a)));
    endtask

    task automatic rd_lit(input string tag, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, 64'(bus_rdata), 64'(exp));
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a <= 8'h30; a += 4) rd_lit("R1 reset word", 8'(a), 32'h0);
        chk("R1 irq", 64'(irq), 64'h0);

        // R13 control and auxiliary words
        wr(8'h00, 32'hFFFF_FFFF);
        rd_lit("R13 ctrl", 8'h00, 32'h8000_000C);
        wr(8'h30, 32'hFFFF_FFFF);
        rd_lit("R13 aux", 8'h30, 32'h0000_0040);
        wr(8'h00, 32'h0000_0008);
        rd("R13 ctrl partial", 8'h00);

        // R2 R3 request enable words and commands
        wr(8'h08, 32'hA5A5_0001);
        wr(8'h0C, 32'h8000_0003);
        rd_lit("R2 reqen lo", 8'h08, 32'hA5A5_0001);
        rd_lit("R2 reqen hi", 8'h0C, 32'h8000_0003);
        wr(8'h40, 32'd40);
        wr(8'h44, 32'd0);
        rd_lit("R3 reqen lo after clear", 8'h08, 32'hA5A5_0000);
        rd_lit("R3 reqen hi after set", 8'h0C, 32'h8000_0103);

        // R4 error interrupt enable
        wr(8'h48, 32'd5);
        wr(8'h48, 32'd63);
        rd_lit("R4 eien lo", 8'h10, 32'h0000_0020);
        rd_lit("R4 eien hi", 8'h14, 32'h8000_0000);
        wr(8'h4C, 32'd63);
        rd("R4 eien hi cleared", 8'h14);

        // R5 R6 done and interrupt pending
        step(1'b0, 8'h00, 32'h0, (64'd1 << 3) | (64'd1 << 40), '0);
        rd_lit("R5 done lo", 8'h28, 32'h0000_0008);
        rd_lit("R5 done hi", 8'h2C, 32'h0000_0100);
        rd_lit("R6 intp lo", 8'h18, 32'h0000_0008);
        chk("R8 irq from pending", 64'(irq), 64'h1);
        wr(8'h18, 32'hFFFF_FFFF);
        rd_lit("R6 intp lo w1c", 8'h18, 32'h0);
        wr(8'h50, 32'd40);
        rd_lit("R6 intp hi cmd", 8'h1C, 32'h0);
        chk("R8 irq idle", 64'(irq), 64'h0);
        wr(8'h5C, 32'd3);
        rd_lit("R5 done lo cleared", 8'h28, 32'h0);
        rd("R5 done hi kept", 8'h2C);
        step(1'b1, 8'h18, 32'h0000_0080, 64'd1 << 7, '0);
        rd_lit("R6 set wins over clear", 8'h18, 32'h0000_0080);
        wr(8'h18, 32'h0000_0080);

        // R7 R8 R10 error pending and capture
        ch_cause[5*CW +: CW]  = 10'b10_1000_0001;
        ch_cause[10*CW +: CW] = 10'b01_0000_0010;
        step(1'b0, 8'h00, 32'h0, '0, (64'd1 << 5) | (64'd1 << 10));
        rd_lit("R7 errp lo", 8'h20, 32'h0000_0420);
        rd_lit("R10 errstat", 8'h04, 32'h8000_8581);
        chk("R8 irq enabled err", 64'(irq), 64'h1);

        // R11 hold and rearm
        ch_cause[2*CW +: CW] = 10'b00_0001_0000;
        step(1'b0, 8'h00, 32'h0, '0, 64'd1 << 2);
        rd_lit("R11 held", 8'h04, 32'h8000_8581);
        wr(8'h54, 32'd10);
        rd_lit("R11 other clear keeps", 8'h04, 32'h8000_8581);
        wr(8'h20, 32'h0000_0004);
        rd("R7 errp w1c", 8'h20);
        wr(8'h54, 32'd5);
        rd_lit("R11 rearmed", 8'h04, 32'h0);
        chk("R8 irq after err clear", 64'(irq), 64'h0);
        ch_cause[45*CW +: CW] = 10'b00_0001_0000;
        step(1'b0, 8'h00, 32'h0, '0, 64'd1 << 45);
        rd_lit("R10 recapture", 8'h04, 32'h8000_2D10);
        chk("R8 err not enabled", 64'(irq), 64'h0);
        wr(8'h24, 32'hFFFF_FFFF);
        rd_lit("R11 rearm via word", 8'h04, 32'h0);
        step(1'b1, 8'h20, 32'h0000_0002, '0, 64'd1 << 1);
        rd_lit("R7 set wins over clear", 8'h20, 32'h0000_0002);

        // R12 out of range commands
        wr(8'h40, 32'd64);
        wr(8'h44, 32'd200);
        wr(8'h48, 32'd255);
        rd_lit("R12 reqen lo", 8'h08, 32'hA5A5_0000);
        rd_lit("R12 reqen hi", 8'h0C, 32'h8000_0103);
        rd("R12 eien lo", 8'h10);
        wr(8'h58, 32'd64);
        chk("R12 no start", ch_start, 64'h0);

        // R9 start pulse
        wr(8'h58, 32'd17);
        chk("R9 start high", ch_start, 64'd1 << 17);
        @(negedge clk);
        chk("R9 start one cycle", ch_start, 64'h0);
        wr(8'h58, 32'd63);
        chk("R9 start ch63", ch_start, 64'd1 << 63);
        @(negedge clk);

        summary();
    end
endmodule